// File: doc/BRIEF.md
# UART Register Bank with Divisor Latch

This block is the byte-wide register front end of a 16550-style serial port. It sits on a Wishbone-style bus with a 3-bit address and turns bus accesses into register updates, read data and single-cycle strobes for the rest of the UART. The block has a data port at offset 0. When the divisor-access bit is clear, a read of that port pops the receive FIFO and a write pushes the transmit FIFO. When the bit is set, offsets 0 and 1 reach the low and high bytes of a 16-bit baud divisor.

The block holds the interrupt-enable, line-control and modem-control registers, the divisor and the receive trigger level, and it drives them out to the other parts of the UART. The interrupt identification, line status, modem status and receive FIFO head come in as inputs and are returned on reads. The FIFOs are always enabled. Writes to the FIFO-control offset produce flush pulses and set the trigger level. The modem-control pins are driven as active-low complements of the written bits.

Top module: `uart_csr_bank`

## Requirements
- R1: After reset the divisor, interrupt enables, line control and loopback are all zero, the trigger level is 1, and dtr_n, rts_n, out1_n and out2_n are all 1.
- R2: Each bus transaction is acknowledged exactly once, one clock after the request is first seen, even if the master holds cyc and stb for several clocks.
- R3: With line-control bit 7 clear, a write to offset 0 gives exactly one tx_push pulse, with tx_data equal to the written byte, in the acknowledge cycle. A read of offset 0 returns rx_data and gives exactly one rx_pop pulse in the acknowledge cycle.
- R4: With line-control bit 7 set, offsets 0 and 1 read and write divisor bits 7:0 and 15:8. These accesses give no push or pop pulse and leave the interrupt enables unchanged.
- R5: With bit 7 clear, offset 1 holds the interrupt enables in bits 3:0. Bits 7:4 read back as zero.
- R6: A read of offset 2 returns iir_in. A write to offset 2 gives one rx_flush pulse if bit 1 is set and one tx_flush pulse if bit 2 is set. Bit 0 has no effect.
- R7: FIFO-control bits 7:6 set trigger_level: 00 gives 1, 01 gives 4, 10 gives 8 and 11 gives 14. The value holds until the next write to offset 2.
- R8: Offset 3 reads and writes all 8 bits of line control, which are driven on lcr_o.
- R9: A write to offset 4 sets loopback from bit 4 and drives dtr_n, rts_n, out1_n and out2_n as the complements of bits 0, 1, 2 and 3. Offset 4 reads back as zero.
- R10: Offset 5 reads lsr_in and offset 6 reads msr_in. Offset 7 reads zero. Writes to offsets 5 to 7 change no output.
- R11: The flush pulses last one clock and are not stored. They are low in every cycle except the acknowledge cycle of the write that caused them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_cyc | input | 1 | Bus cycle valid |
| bus_stb | input | 1 | Bus strobe |
| bus_we | input | 1 | Write enable |
| bus_adr | input | 3 | Register offset |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, valid with bus_ack |
| bus_ack | output | 1 | Transaction acknowledge |
| rx_data | input | 8 | Head byte of the receive FIFO |
| iir_in | input | 8 | Interrupt identification value |
| lsr_in | input | 8 | Line status value |
| msr_in | input | 8 | Modem status value |
| tx_push | output | 1 | Transmit FIFO push pulse |
| tx_data | output | 8 | Byte to push |
| rx_pop | output | 1 | Receive FIFO pop pulse |
| rx_flush | output | 1 | Receive FIFO flush pulse |
| tx_flush | output | 1 | Transmit FIFO flush pulse |
| trigger_level | output | 4 | Receive trigger level in bytes |
| divisor | output | 16 | Baud divisor |
| ier_o | output | 4 | Interrupt enables |
| lcr_o | output | 8 | Line control |
| loopback | output | 1 | Loopback enable |
| dtr_n | output | 1 | DTR pin, active low |
| rts_n | output | 1 | RTS pin, active low |
| out1_n | output | 1 | OUT1 pin, active low |
| out2_n | output | 1 | OUT2 pin, active low |

## Verification
The checker watches several rules on every clock: each acknowledge lasts one cycle, each strobe comes only with an acknowledge, each flush pulse lasts one cycle, the divisor holds while the access bit is clear, the trigger level is always one of its four legal values, and the reset state is correct. Only the bench scenarios can show the address decoding itself. That covers the swap between the divisor and the data or enable registers, the returned read values, the trigger encoding, the modem pin complements, and the rule that a held bus cycle still gives a single pulse.

// File: rtl/uart_csr_pkg.sv
package uart_csr_pkg;

    localparam int DATA_W  = 8;
    localparam int ADDR_W  = 3;
    localparam int DIV_W   = 16;
    localparam int IER_W   = 4;
    localparam int TRIG_W  = 4;

    typedef enum logic [ADDR_W-1:0] {
        OFS_DATA  = 3'd0,
        OFS_IER   = 3'd1,
        OFS_FIFO  = 3'd2,
        OFS_LINE  = 3'd3,
        OFS_MODEM = 3'd4,
        OFS_LSTAT = 3'd5,
        OFS_MSTAT = 3'd6,
        OFS_SPARE = 3'd7
    } csr_ofs_e;

    typedef struct packed {
        logic                  wr;
        logic                  rd;
        csr_ofs_e              ofs;
        logic [DATA_W-1:0]     wdata;
    } csr_access_t;

    typedef struct packed {
        logic       loop_en;
        logic       out2;
        logic       out1;
        logic       rts;
        logic       dtr;
    } modem_ctl_t;

    localparam int DLAB_BIT = 7;

    function automatic logic [TRIG_W-1:0] trig_bytes(input logic [1:0] code);
        case (code)
            2'b00:   trig_bytes = TRIG_W'(1);
            2'b01:   trig_bytes = TRIG_W'(4);
            2'b10:   trig_bytes = TRIG_W'(8);
            default: trig_bytes = TRIG_W'(14);
        endcase
    endfunction

endpackage

// File: rtl/uart_bus_slave.sv
module uart_bus_slave
    import uart_csr_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 cyc,
    input  logic                 stb,
    input  logic                 we,
    input  logic [ADDR_W-1:0]    adr,
    input  logic [DATA_W-1:0]    wdata,
    output csr_access_t          acc,
    output logic                 ack
);
    logic req;
    logic busy_q;
    logic take;

    assign req  = cyc & stb;
    assign take = req & ~busy_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            busy_q <= 1'b0;
            ack    <= 1'b0;
        end else begin
            busy_q <= req;
            ack    <= take;
        end
    end

    always_comb begin
        acc.wr    = take & we;
        acc.rd    = take & ~we;
        acc.ofs   = csr_ofs_e'(adr);
        acc.wdata = wdata;
    end
endmodule

// File: rtl/uart_ctrl_regs.sv
module uart_ctrl_regs
    import uart_csr_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  csr_access_t          acc,
    output logic [DIV_W-1:0]     div_q,
    output logic [IER_W-1:0]     ier_q,
    output logic [DATA_W-1:0]    lcr_q,
    output modem_ctl_t           mcr_q,
    output logic [1:0]           trig_q,
    output logic                 push_q,
    output logic [DATA_W-1:0]    push_data_q,
    output logic                 pop_q,
    output logic                 rx_flush_q,
    output logic                 tx_flush_q
);
    localparam int DIV_BYTES = DIV_W / DATA_W;

    logic dlab;
    assign dlab = lcr_q[DLAB_BIT];

    logic unused_wbits;
    assign unused_wbits = ^{acc.wdata[5:3], acc.wdata[0], acc.wdata[7:5]};

    for (genvar b = 0; b < DIV_BYTES; b++) begin : g_div
        always_ff @(posedge clk) begin
            if (rst)
                div_q[b*DATA_W +: DATA_W] <= '0;
            else if (acc.wr && dlab && acc.ofs == csr_ofs_e'(b))
                div_q[b*DATA_W +: DATA_W] <= acc.wdata;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ier_q  <= '0;
            lcr_q  <= '0;
            mcr_q  <= '0;
            trig_q <= 2'b00;
        end else if (acc.wr) begin
            case (acc.ofs)
                OFS_IER:   if (!dlab) ier_q <= acc.wdata[IER_W-1:0];
                OFS_FIFO:  trig_q <= acc.wdata[7:6];
                OFS_LINE:  lcr_q  <= acc.wdata;
                OFS_MODEM: mcr_q  <= modem_ctl_t'(acc.wdata[4:0]);
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            push_q      <= 1'b0;
            push_data_q <= '0;
            pop_q       <= 1'b0;
            rx_flush_q  <= 1'b0;
            tx_flush_q  <= 1'b0;
        end else begin
            push_q     <= acc.wr & ~dlab & (acc.ofs == OFS_DATA);
            pop_q      <= acc.rd & ~dlab & (acc.ofs == OFS_DATA);
            rx_flush_q <= acc.wr & (acc.ofs == OFS_FIFO) & acc.wdata[1];
            tx_flush_q <= acc.wr & (acc.ofs == OFS_FIFO) & acc.wdata[2];
            if (acc.wr && !dlab && acc.ofs == OFS_DATA)
                push_data_q <= acc.wdata;
        end
    end
endmodule

// File: rtl/uart_rd_mux.sv
module uart_rd_mux
    import uart_csr_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  csr_access_t          acc,
    input  logic [DIV_W-1:0]     div_q,
    input  logic [IER_W-1:0]     ier_q,
    input  logic [DATA_W-1:0]    lcr_q,
    input  logic [DATA_W-1:0]    rx_data,
    input  logic [DATA_W-1:0]    iir_in,
    input  logic [DATA_W-1:0]    lsr_in,
    input  logic [DATA_W-1:0]    msr_in,
    output logic [DATA_W-1:0]    rdata_q
);
    logic              dlab;
    logic [DATA_W-1:0] sel;

    assign dlab = lcr_q[DLAB_BIT];

    always_comb begin
        case (acc.ofs)
            OFS_DATA:  sel = dlab ? div_q[DATA_W-1:0] : rx_data;
            OFS_IER:   sel = dlab ? div_q[2*DATA_W-1:DATA_W]
                                  : {{(DATA_W-IER_W){1'b0}}, ier_q};
            OFS_FIFO:  sel = iir_in;
            OFS_LINE:  sel = lcr_q;
            OFS_LSTAT: sel = lsr_in;
            OFS_MSTAT: sel = msr_in;
            default:   sel = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst)
            rdata_q <= '0;
        else if (acc.rd)
            rdata_q <= sel;
    end
endmodule

// File: rtl/uart_csr_bank.sv
module uart_csr_bank
    import uart_csr_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 bus_cyc,
    input  logic                 bus_stb,
    input  logic                 bus_we,
    input  logic [ADDR_W-1:0]    bus_adr,
    input  logic [DATA_W-1:0]    bus_wdata,
    output logic [DATA_W-1:0]    bus_rdata,
    output logic                 bus_ack,
    input  logic [DATA_W-1:0]    rx_data,
    input  logic [DATA_W-1:0]    iir_in,
    input  logic [DATA_W-1:0]    lsr_in,
    input  logic [DATA_W-1:0]    msr_in,
    output logic                 tx_push,
    output logic [DATA_W-1:0]    tx_data,
    output logic                 rx_pop,
    output logic                 rx_flush,
    output logic                 tx_flush,
    output logic [TRIG_W-1:0]    trigger_level,
    output logic [DIV_W-1:0]     divisor,
    output logic [IER_W-1:0]     ier_o,
    output logic [DATA_W-1:0]    lcr_o,
    output logic                 loopback,
    output logic                 dtr_n,
    output logic                 rts_n,
    output logic                 out1_n,
    output logic                 out2_n
);
    csr_access_t acc;
    modem_ctl_t  mcr;
    logic [1:0]  trig_code;

    uart_bus_slave u_bus (
        .clk   (clk),
        .rst   (rst),
        .cyc   (bus_cyc),
        .stb   (bus_stb),
        .we    (bus_we),
        .adr   (bus_adr),
        .wdata (bus_wdata),
        .acc   (acc),
        .ack   (bus_ack)
    );

    uart_ctrl_regs u_regs (
        .clk         (clk),
        .rst         (rst),
        .acc         (acc),
        .div_q       (divisor),
        .ier_q       (ier_o),
        .lcr_q       (lcr_o),
        .mcr_q       (mcr),
        .trig_q      (trig_code),
        .push_q      (tx_push),
        .push_data_q (tx_data),
        .pop_q       (rx_pop),
        .rx_flush_q  (rx_flush),
        .tx_flush_q  (tx_flush)
    );

    uart_rd_mux u_rd (
        .clk     (clk),
        .rst     (rst),
        .acc     (acc),
        .div_q   (divisor),
        .ier_q   (ier_o),
        .lcr_q   (lcr_o),
        .rx_data (rx_data),
        .iir_in  (iir_in),
        .lsr_in  (lsr_in),
        .msr_in  (msr_in),
        .rdata_q (bus_rdata)
    );

    assign trigger_level = trig_bytes(trig_code);
    assign loopback      = mcr.loop_en;
    assign dtr_n         = ~mcr.dtr;
    assign rts_n         = ~mcr.rts;
    assign out1_n        = ~mcr.out1;
    assign out2_n        = ~mcr.out2;
endmodule

// File: rtl/uart_csr_bank_chk.sv
module uart_csr_bank_chk
    import uart_csr_pkg::*;
(
    input logic               clk,
    input logic               rst,
    input logic               bus_ack,
    input logic               tx_push,
    input logic               rx_pop,
    input logic               rx_flush,
    input logic               tx_flush,
    input logic [TRIG_W-1:0]  trigger_level,
    input logic [DIV_W-1:0]   divisor,
    input logic [DATA_W-1:0]  lcr_o
);
    // R2
    ack_single_chk: assert property (@(posedge clk) disable iff (rst)
        bus_ack |=> !bus_ack);

    // R3
    push_with_ack_chk: assert property (@(posedge clk) disable iff (rst)
        tx_push |-> bus_ack);

    // R3
    pop_with_ack_chk: assert property (@(posedge clk) disable iff (rst)
        rx_pop |-> (bus_ack && !tx_push));

    // R11
    rx_flush_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        rx_flush |-> bus_ack ##1 !rx_flush);

    // R11
    tx_flush_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        tx_flush |-> bus_ack ##1 !tx_flush);

    // R4
    div_locked_chk: assert property (@(posedge clk) disable iff (rst)
        !lcr_o[DLAB_BIT] |=> $stable(divisor));

    // R7
    trig_legal_chk: assert property (@(posedge clk) disable iff (rst)
        (trigger_level == 4'd1 || trigger_level == 4'd4 ||
         trigger_level == 4'd8 || trigger_level == 4'd14));

    // R1
    reset_state_chk: assert property (@(posedge clk)
        rst |=> (divisor == '0 && lcr_o == '0 && trigger_level == 4'd1));
endmodule

bind uart_csr_bank uart_csr_bank_chk u_chk (
    .clk           (clk),
    .rst           (rst),
    .bus_ack       (bus_ack),
    .tx_push       (tx_push),
    .rx_pop        (rx_pop),
    .rx_flush      (rx_flush),
    .tx_flush      (tx_flush),
    .trigger_level (trigger_level),
    .divisor       (divisor),
    .lcr_o         (lcr_o)
);

// File: tb/uart_csr_bank_tb_top.sv
module uart_csr_bank_tb_top;
    logic clk = 1'b0;
    logic rst;
    logic cyc, stb, we;
    logic [2:0] adr;
    logic [7:0] wdat, rdat, rx_data, iir_in, lsr_in, msr_in, tx_data, lcr_o;
    logic ack, tx_push, rx_pop, rx_flush, tx_flush, loopback;
    logic dtr_n, rts_n, out1_n, out2_n;
    logic [3:0] trig, ier_o;
    logic [15:0] divisor;

    int n_run  = 0;
    int n_fail = 0;

    always #2 clk = ~clk;

    uart_csr_bank dut_i (
        .clk(clk), .rst(rst), .bus_cyc(cyc), .bus_stb(stb), .bus_we(we),
        .bus_adr(adr), .bus_wdata(wdat), .bus_rdata(rdat), .bus_ack(ack),
        .rx_data(rx_data), .iir_in(iir_in), .lsr_in(lsr_in), .msr_in(msr_in),
        .tx_push(tx_push), .tx_data(tx_data), .rx_pop(rx_pop),
        .rx_flush(rx_flush), .tx_flush(tx_flush), .trigger_level(trig),
        .divisor(divisor), .ier_o(ier_o), .lcr_o(lcr_o), .loopback(loopback),
        .dtr_n(dtr_n), .rts_n(rts_n), .out1_n(out1_n), .out2_n(out2_n)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    // One bus transaction held for 'hold' clocks, counting every pulse seen.
    int   c_ack, c_push, c_pop, c_rxf, c_txf;
    logic [7:0] got, pushed;

    task automatic sample();
        @(posedge clk); #1;
        if (ack) begin c_ack++; got = rdat; end
        if (tx_push) begin c_push++; pushed = tx_data; end
        if (rx_pop) c_pop++;
        if (rx_flush) c_rxf++;
        if (tx_flush) c_txf++;
    endtask

    task automatic xfer(input logic w, input logic [2:0] a, input logic [7:0] d, input int hold);
        c_ack = 0; c_push = 0; c_pop = 0; c_rxf = 0; c_txf = 0; got = 8'hxx;
        @(negedge clk);
        cyc = 1; stb = 1; we = w; adr = a; wdat = d;
        for (int i = 0; i < hold; i++) sample();
        @(negedge clk);
        cyc = 0; stb = 0; we = 0;
        sample();
        sample();
    endtask

    task automatic t_reset();
        chk("R1 divisor", divisor, 0);
        chk("R1 lcr", lcr_o, 0);
        chk("R1 ier", ier_o, 0);
        chk("R1 loop", loopback, 0);
        chk("R1 pins", {dtr_n, rts_n, out1_n, out2_n}, 4'hF);
        chk("R1 trig", trig, 1);
    endtask

    task automatic t_data_port();
        xfer(1, 3'd0, 8'hA5, 1);
        chk("R2 ack count", c_ack, 1);
        chk("R3 push count", c_push, 1);
        chk("R3 push data", pushed, 8'hA5);
        rx_data = 8'h3C;
        xfer(0, 3'd0, 0, 1);
        chk("R3 read data", got, 8'h3C);
        chk("R3 pop count", c_pop, 1);
        xfer(1, 3'd0, 8'h11, 4);
        chk("R2 held ack", c_ack, 1);
        chk("R3 held push", c_push, 1);
        xfer(0, 3'd0, 0, 3);
        chk("R3 held pop", c_pop, 1);
    endtask

    task automatic t_ier();
        xfer(1, 3'd1, 8'hFB, 1);
        chk("R5 ier out", ier_o, 4'hB);
        xfer(0, 3'd1, 0, 1);
        chk("R5 ier read", got, 8'h0B);
    endtask

    task automatic t_divisor();
        xfer(1, 3'd3, 8'h83, 1);
        chk("R8 lcr out", lcr_o, 8'h83);
        xfer(1, 3'd0, 8'h34, 1);
        chk("R4 no push", c_push, 0);
        xfer(1, 3'd1, 8'h12, 1);
        chk("R4 divisor", divisor, 16'h1234);
        chk("R4 ier kept", ier_o, 4'hB);
        xfer(0, 3'd0, 0, 1);
        chk("R4 read lo", got, 8'h34);
        chk("R4 no pop", c_pop, 0);
        xfer(0, 3'd1, 0, 1);
        chk("R4 read hi", got, 8'h12);
        xfer(1, 3'd3, 8'h1B, 1);
        xfer(0, 3'd3, 0, 1);
        chk("R8 lcr read", got, 8'h1B);
        xfer(1, 3'd0, 8'h99, 1);
        chk("R4 divisor kept", divisor, 16'h1234);
        chk("R3 push after clear", c_push, 1);
    endtask

    task automatic t_fifo_ctl();
        iir_in = 8'hC4;
        xfer(0, 3'd2, 0, 1);
        chk("R6 iir read", got, 8'hC4);
        xfer(1, 3'd2, 8'h01, 1);
        chk("R6 bit0 no rx flush", c_rxf, 0);
        chk("R6 bit0 no tx flush", c_txf, 0);
        chk("R7 trig 00", trig, 1);
        xfer(1, 3'd2, 8'h42, 3);
        chk("R6 rx flush", c_rxf, 1);
        chk("R11 rx flush once", c_txf, 0);
        chk("R7 trig 01", trig, 4);
        xfer(1, 3'd2, 8'h84, 1);
        chk("R6 tx flush", c_txf, 1);
        chk("R11 no rx", c_rxf, 0);
        chk("R7 trig 10", trig, 8);
        xfer(1, 3'd2, 8'hC6, 1);
        chk("R11 both", c_rxf + c_txf, 2);
        chk("R7 trig 11", trig, 14);
        chk("R11 flush low", {rx_flush, tx_flush}, 0);
        xfer(1, 3'd3, 8'h00, 1);
        chk("R7 trig held", trig, 14);
    endtask

    task automatic t_modem();
        xfer(1, 3'd4, 8'h15, 1);
        chk("R9 loop", loopback, 1);
        chk("R9 pins", {out2_n, out1_n, rts_n, dtr_n}, 4'hA);
        xfer(1, 3'd4, 8'h0A, 1);
        chk("R9 loop off", loopback, 0);
        chk("R9 pins2", {out2_n, out1_n, rts_n, dtr_n}, 4'h5);
        xfer(0, 3'd4, 0, 1);
        chk("R9 read zero", got, 0);
    endtask

    task automatic t_status();
        lsr_in = 8'h61; msr_in = 8'hB2;
        xfer(0, 3'd5, 0, 1);
        chk("R10 lsr", got, 8'h61);
        xfer(0, 3'd6, 0, 1);
        chk("R10 msr", got, 8'hB2);
        xfer(0, 3'd7, 0, 1);
        chk("R10 spare", got, 0);
        for (int a = 5; a < 8; a++) xfer(1, 3'(a), 8'hFF, 1);
        chk("R10 ignored", {divisor, ier_o, lcr_o, loopback, out2_n, out1_n, rts_n, dtr_n, trig},
            {16'h1234, 4'hB, 8'h00, 1'b0, 4'h5, 4'd14});
    endtask

    initial begin
        #400000;
        n_run++; n_fail++;
        $display("FAIL watchdog: actual hung expected done");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        cyc = 0; stb = 0; we = 0; adr = 0; wdat = 0;
        rx_data = 0; iir_in = 8'h01; lsr_in = 0; msr_in = 0;
        rst = 1;
        repeat (3) @(posedge clk);
        @(negedge clk); rst = 0;
        #1;
        t_reset();
        t_data_port();
        t_ier();
        t_divisor();
        t_fifo_ctl();
        t_modem();
        t_status();
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule